// File: doc/BRIEF.md
# Redundant Frame Sequence Checker

This block sits on the receive side of an end system that hears every frame twice, once over network A and once over network B. For each frame header presented on a one-cycle strobe it is told the virtual-link index, the 8-bit sequence number, the network the frame came in on, whether its checksum passed, and the current value of a free-running timestamp. It answers with a registered deliver/discard decision and an error code. The host therefore sees each frame once and in order.

Per virtual link the block remembers four things: whether the link is being tracked, the last accepted sequence number, the network and arrival time of that number's first copy, and whether the last number was the sender-reset value 0. Sequence numbers run 1..255 and then wrap to 1. The value 0 only appears when a sender restarts. The second copy of a frame is recognised as a duplicate only while it is still inside a configurable skew window, measured in timestamp ticks. After that window it counts as a stale, out-of-order number.

Top module: `seqchk_top`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `dec_valid` is 0. Every link starts untracked.
- R2: Each strobe on `frm_valid` produces exactly one decision, with `dec_valid` high in the cycle after the strobe. A cycle without a strobe yields `dec_valid` low in the following cycle. Back-to-back strobes are allowed.
- R3: A frame with `frm_crc_ok` low is discarded with error code 1 (checksum). This rule comes before every other rule. The frame still becomes the link's last number, with its network and time, so the next number after it is in order.
- R4: A good frame with sequence number 0 is always delivered with code 0. After it, the next good number of any value on that link is delivered.
- R5: The first good frame on an untracked link is delivered whatever its number.
- R6: A good frame whose number is the last number plus one or plus two is delivered with code 0. The step after 255 is 1, never 0, so 255 is followed by 1 or 2, and 254 by 255 or 1.
- R7: A good frame that repeats the last number, arrives on the other network, and has an age of at most the effective skew is discarded with code 3 (duplicate). Age is the current time minus the time stored for the last number. The link state is left unchanged.
- R8: A repeated number whose age exceeds the effective skew is discarded with code 2 (ordering).
- R9: Any other good number is discarded with code 2. The stored expectation is left unchanged, so a later correct successor is still delivered.
- R10: The effective skew is `cfg_skew` clamped to the parameter `SKEW_MAX` (default 5000 ticks, which is 5 ms at a 1 µs tick).
- R11: The state of each link is independent. A frame for one link never alters the decision for another link.
- R12: Age is computed modulo 2^`TS_W`, so a pair of copies that straddles a timestamp wrap is still judged by its true distance.
- R13: A repeat of the last number on the same network as its first copy is discarded with code 2, even inside the skew window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe marking a frame header |
| frm_link | input | LINK_W (4) | Virtual-link index |
| frm_seq | input | 8 | Frame sequence number |
| frm_net | input | 1 | Network of arrival: 0 = A, 1 = B |
| frm_crc_ok | input | 1 | Checksum passed |
| now_tick | input | TS_W (16) | Free-running timestamp |
| cfg_skew | input | TS_W (16) | Duplicate window in ticks, before clamping |
| dec_valid | output | 1 | Decision strobe, one cycle after `frm_valid` |
| dec_deliver | output | 1 | 1 = hand the frame to the host, 0 = discard |
| dec_err | output | 2 | 0 none, 1 checksum, 2 ordering, 3 duplicate |

## Verification
A checksum failure and duplicate detection can both apply to the same frame. This happens when a corrupted copy arrives on the second network inside the skew window of its good twin. The bench provokes it in both orders: a bad first copy followed by a good twin, and a good first copy followed by a bad twin. It expects code 3 for the first order and code 1 for the second. Wrap handling and the skew test also meet in one frame when the timestamp wraps between two copies. The reference model computes age with integer arithmetic modulo 65536 and clamps the skew itself, and it compares every decision cycle and every idle cycle.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;

  localparam int SEQ_W = 8;

  typedef logic [SEQ_W-1:0] seq_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_CRC   = 2'd1,
    ERR_ORDER = 2'd2,
    ERR_DUP   = 2'd3
  } err_e;

  // Successor of a sequence number: 255 steps to 1, 0 is never produced.
  function automatic seq_t seq_next(input seq_t s);
    seq_t r;
    if (s == {SEQ_W{1'b1}}) r = seq_t'(1);
    else                    r = s + seq_t'(1);
    return r;
  endfunction

  // True when cand is one or two steps after last.
  function automatic logic seq_in_step(input seq_t last, input seq_t cand);
    seq_t n1;
    seq_t n2;
    n1 = seq_next(last);
    n2 = seq_next(n1);
    return (cand == n1) || (cand == n2);
  endfunction

endpackage

// File: rtl/seqchk_linkstore.sv
module seqchk_linkstore
  import seqchk_pkg::*;
#(
  parameter int LINKS  = 16,
  parameter int LINK_W = $clog2(LINKS),
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINK_W-1:0] rd_idx,
  output logic              rd_trk,
  output logic              rd_fresh,
  output logic              rd_net,
  output seq_t              rd_seq,
  output logic [TS_W-1:0]   rd_ts,
  input  logic              wr_en,
  input  logic [LINK_W-1:0] wr_idx,
  input  logic              wr_fresh,
  input  logic              wr_net,
  input  seq_t              wr_seq,
  input  logic [TS_W-1:0]   wr_ts
);

  logic            trk_q   [LINKS];
  logic            fresh_q [LINKS];
  logic            net_q   [LINKS];
  seq_t            seq_q   [LINKS];
  logic [TS_W-1:0] ts_q    [LINKS];
  logic [LINKS-1:0] wr_hit;

  for (genvar g = 0; g < LINKS; g++) begin : g_link
    assign wr_hit[g] = wr_en && (wr_idx == LINK_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        trk_q[g]   <= 1'b0;
        fresh_q[g] <= 1'b0;
        net_q[g]   <= 1'b0;
        seq_q[g]   <= '0;
        ts_q[g]    <= '0;
      end else if (wr_hit[g]) begin
        trk_q[g]   <= 1'b1;
        fresh_q[g] <= wr_fresh;
        net_q[g]   <= wr_net;
        seq_q[g]   <= wr_seq;
        ts_q[g]    <= wr_ts;
      end
    end

    // R11: a link not addressed by the write keeps its state
    a_r11_idle_link_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[g] |=> ($stable(seq_q[g]) && $stable(trk_q[g]) && $stable(ts_q[g])));
  end

  assign rd_trk   = trk_q[rd_idx];
  assign rd_fresh = fresh_q[rd_idx];
  assign rd_net   = net_q[rd_idx];
  assign rd_seq   = seq_q[rd_idx];
  assign rd_ts    = ts_q[rd_idx];

endmodule

// File: rtl/seqchk_judge.sv
module seqchk_judge
  import seqchk_pkg::*;
#(
  parameter int TS_W     = 16,
  parameter int SKEW_MAX = 5000
) (
  input  logic            frm_crc_ok,
  input  logic            frm_net,
  input  seq_t            frm_seq,
  input  logic [TS_W-1:0] now_tick,
  input  logic [TS_W-1:0] cfg_skew,
  input  logic            st_trk,
  input  logic            st_fresh,
  input  logic            st_net,
  input  seq_t            st_seq,
  input  logic [TS_W-1:0] st_ts,
  output logic            take,
  output err_e            err,
  output logic            upd,
  output logic            upd_fresh,
  output logic [TS_W-1:0] skew_eff,
  output logic            dup_hit,
  output logic            step_ok
);

  localparam logic [TS_W-1:0] SKEW_CAP = TS_W'(SKEW_MAX);

  logic [TS_W-1:0] age;
  logic            in_window;
  logic            same_num;
  logic            is_restart;
  logic            open_start;

  // Modular age so a wrapping timestamp still gives the true distance.
  assign age        = now_tick - st_ts;
  assign skew_eff   = (cfg_skew > SKEW_CAP) ? SKEW_CAP : cfg_skew;
  assign in_window  = (age <= skew_eff);
  assign same_num   = st_trk && (frm_seq == st_seq);
  assign dup_hit    = same_num && (frm_net != st_net) && in_window;
  assign step_ok    = seq_in_step(st_seq, frm_seq);
  assign is_restart = (frm_seq == '0);
  assign open_start = !st_trk || st_fresh;

  always_comb begin
    take      = 1'b0;
    err       = ERR_ORDER;
    upd       = 1'b0;
    upd_fresh = 1'b0;
    if (!frm_crc_ok) begin
      err       = ERR_CRC;
      upd       = 1'b1;
      upd_fresh = is_restart;
    end else if (is_restart) begin
      take      = 1'b1;
      err       = ERR_NONE;
      upd       = 1'b1;
      upd_fresh = 1'b1;
    end else if (open_start) begin
      take = 1'b1;
      err  = ERR_NONE;
      upd  = 1'b1;
    end else if (dup_hit) begin
      err = ERR_DUP;
    end else if (step_ok) begin
      take = 1'b1;
      err  = ERR_NONE;
      upd  = 1'b1;
    end
  end

endmodule

// File: rtl/seqchk_top.sv
module seqchk_top
  import seqchk_pkg::*;
#(
  parameter int LINKS    = 16,
  parameter int LINK_W   = $clog2(LINKS),
  parameter int TS_W     = 16,
  parameter int SKEW_MAX = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [LINK_W-1:0] frm_link,
  input  logic [7:0]        frm_seq,
  input  logic              frm_net,
  input  logic              frm_crc_ok,
  input  logic [TS_W-1:0]   now_tick,
  input  logic [TS_W-1:0]   cfg_skew,
  output logic              dec_valid,
  output logic              dec_deliver,
  output logic [1:0]        dec_err
);

  logic            st_trk, st_fresh, st_net;
  seq_t            st_seq;
  logic [TS_W-1:0] st_ts;
  logic            j_take, j_upd, j_upd_fresh, j_dup, j_step;
  err_e            j_err;
  logic [TS_W-1:0] skew_eff;
  logic            wr_en;

  assign wr_en = frm_valid && j_upd;

  seqchk_linkstore #(.LINKS(LINKS), .LINK_W(LINK_W), .TS_W(TS_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (frm_link),
    .rd_trk   (st_trk),
    .rd_fresh (st_fresh),
    .rd_net   (st_net),
    .rd_seq   (st_seq),
    .rd_ts    (st_ts),
    .wr_en    (wr_en),
    .wr_idx   (frm_link),
    .wr_fresh (j_upd_fresh),
    .wr_net   (frm_net),
    .wr_seq   (frm_seq),
    .wr_ts    (now_tick)
  );

  seqchk_judge #(.TS_W(TS_W), .SKEW_MAX(SKEW_MAX)) u_judge (
    .frm_crc_ok (frm_crc_ok),
    .frm_net    (frm_net),
    .frm_seq    (frm_seq),
    .now_tick   (now_tick),
    .cfg_skew   (cfg_skew),
    .st_trk     (st_trk),
    .st_fresh   (st_fresh),
    .st_net     (st_net),
    .st_seq     (st_seq),
    .st_ts      (st_ts),
    .take       (j_take),
    .err        (j_err),
    .upd        (j_upd),
    .upd_fresh  (j_upd_fresh),
    .skew_eff   (skew_eff),
    .dup_hit    (j_dup),
    .step_ok    (j_step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_deliver <= 1'b0;
      dec_err     <= ERR_NONE;
    end else begin
      dec_valid   <= frm_valid;
      dec_deliver <= frm_valid && j_take;
      dec_err     <= frm_valid ? j_err : ERR_NONE;
    end
  end

  // R2: one decision per strobe, one cycle later
  a_r2_decision_follows: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> dec_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !dec_valid);
  // R3: checksum failures are never delivered
  a_r3_crc_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_crc_ok) |=> (!dec_deliver && dec_err == ERR_CRC));
  // R4: a good restart number is always delivered
  a_r4_restart_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_crc_ok && frm_seq == 8'd0) |=> dec_deliver);
  // R7: a duplicate leaves the link state untouched
  a_r7_dup_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_crc_ok && j_dup && st_trk && !st_fresh && frm_seq != 8'd0) |-> !wr_en);
  // R6: a delivered frame carries no error
  a_r6_clean_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_deliver) |-> dec_err == ERR_NONE);
  // R10: window never exceeds the configured ceiling
  a_r10_skew_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    skew_eff <= TS_W'(SKEW_MAX));

endmodule

// File: tb/tb_seqchk_top.sv
module tb_seqchk_top;
  localparam int CLK_PERIOD = 10;
  localparam int SKEW_MAX   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [3:0]  frm_link = '0;
  logic [7:0]  frm_seq = '0;
  logic        frm_net = 1'b0;
  logic        frm_crc_ok = 1'b0;
  logic [15:0] now_tick = '0;
  logic [15:0] cfg_skew = 16'd100;
  logic        dec_valid, dec_deliver;
  logic [1:0]  dec_err;

  int n_cmp = 0;
  int n_bad = 0;

  int m_trk [16];
  int m_fresh [16];
  int m_seq [16];
  int m_net [16];
  int m_ts [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  seqchk_top #(.SKEW_MAX(SKEW_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_link(frm_link),
    .frm_seq(frm_seq), .frm_net(frm_net), .frm_crc_ok(frm_crc_ok),
    .now_tick(now_tick), .cfg_skew(cfg_skew),
    .dec_valid(dec_valid), .dec_deliver(dec_deliver), .dec_err(dec_err)
  );

  function automatic int succ(int s);
    return (s % 255) + 1;
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Model one frame, drive it, and compare the decision one cycle later.
  task automatic send(int lk, int sq, int nt, int ok, int ts, string tag);
    int exp_d, exp_e, eff, age, wr, fr;
    eff = (cfg_skew > SKEW_MAX) ? SKEW_MAX : int'(cfg_skew);
    age = (ts - m_ts[lk] + 65536) % 65536;
    exp_d = 0; exp_e = 2; wr = 0; fr = 0;
    if (ok == 0) begin
      exp_e = 1; wr = 1; fr = (sq == 0);
    end else if (sq == 0) begin
      exp_d = 1; exp_e = 0; wr = 1; fr = 1;
    end else if (m_trk[lk] == 0 || m_fresh[lk] == 1) begin
      exp_d = 1; exp_e = 0; wr = 1;
    end else if (sq == m_seq[lk] && nt != m_net[lk] && age <= eff) begin
      exp_e = 3;
    end else if (sq == succ(m_seq[lk]) || sq == succ(succ(m_seq[lk]))) begin
      exp_d = 1; exp_e = 0; wr = 1;
    end
    if (wr == 1) begin
      m_trk[lk] = 1; m_fresh[lk] = fr; m_seq[lk] = sq; m_net[lk] = nt; m_ts[lk] = ts;
    end
    frm_valid = 1'b1; frm_link = 4'(lk); frm_seq = 8'(sq);
    frm_net = 1'(nt); frm_crc_ok = 1'(ok); now_tick = 16'(ts);
    @(negedge clk);
    frm_valid = 1'b0;
    n_cmp++;
    if (dec_valid !== 1'b1 || dec_deliver !== 1'(exp_d) || dec_err !== 2'(exp_e)) begin
      n_bad++;
      $display("FAIL %s link %0d seq %0d: got v=%0b d=%0b e=%0d, expected v=1 d=%0d e=%0d",
               tag, lk, sq, dec_valid, dec_deliver, dec_err, exp_d, exp_e);
    end
  endtask

  task automatic idle(string tag);
    frm_valid = 1'b0;
    @(negedge clk);
    n_cmp++;
    if (dec_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s idle: got dec_valid=%0b, expected 0", tag, dec_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_trk[i] = 0; m_fresh[i] = 0; m_seq[i] = 0; m_net[i] = 0; m_ts[i] = 0;
    end
    repeat (3) @(negedge clk);
    n_cmp++;
    if (dec_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 in reset: got dec_valid=%0b, expected 0", dec_valid);
    end
    rst_n = 1'b1;
    idle("R1");
    idle("R2");

    // R5 first frame; R6 +1 and +2; R9 gap then recovery
    send(3, 77, 0, 1, 10, "R5");
    send(3, 78, 0, 1, 20, "R6");
    send(3, 80, 0, 1, 30, "R6");
    send(3, 83, 0, 1, 40, "R9");
    send(3, 81, 0, 1, 50, "R9");
    // R7 twin on network B within window; R13 same-network repeat; R8 after window
    send(3, 81, 1, 1, 60, "R7");
    send(3, 81, 0, 1, 70, "R13");
    send(3, 81, 1, 1, 200, "R8");
    idle("R2");

    // R6 wrap: 254,255,1 and 253,255,2
    send(5, 254, 0, 1, 300, "R5");
    send(5, 255, 0, 1, 310, "R6");
    send(5, 1, 0, 1, 320, "R6");
    send(6, 253, 1, 1, 330, "R5");
    send(6, 255, 1, 1, 340, "R6");
    send(6, 2, 1, 1, 350, "R6");
    send(6, 0, 1, 1, 360, "R4");
    send(6, 3, 1, 1, 370, "R9");

    // R3 checksum failure advances expectation; CRC vs duplicate in both orders
    send(7, 10, 0, 1, 400, "R5");
    send(7, 11, 0, 0, 410, "R3");
    send(7, 12, 1, 1, 420, "R3");
    send(7, 13, 0, 0, 430, "R3");
    send(7, 13, 1, 1, 440, "R7");
    send(7, 14, 0, 1, 450, "R6");
    send(7, 14, 1, 0, 460, "R3");

    // R4 restart then arbitrary start, then its twin copy as duplicate
    send(7, 0, 0, 1, 500, "R4");
    send(7, 0, 1, 1, 505, "R4");
    send(7, 200, 0, 1, 510, "R4");
    send(7, 200, 1, 1, 515, "R7");
    send(7, 201, 0, 1, 520, "R6");

    // R10 skew clamp
    cfg_skew = 16'd60000;
    send(8, 50, 0, 1, 1000, "R5");
    send(8, 50, 1, 1, 6000, "R10");
    send(8, 51, 0, 1, 7000, "R6");
    send(8, 51, 1, 1, 12001, "R10");
    cfg_skew = 16'd100;

    // R12 timestamp wrap between copies
    send(9, 40, 0, 1, 65530, "R5");
    send(9, 40, 1, 1, 4, "R12");
    send(9, 41, 1, 1, 65500, "R6");
    send(9, 41, 0, 1, 100, "R12");

    // R11 interleaved links
    send(1, 20, 0, 1, 2000, "R11");
    send(2, 90, 0, 1, 2001, "R11");
    send(1, 21, 0, 1, 2002, "R11");
    send(2, 21, 0, 1, 2003, "R11");
    send(2, 91, 0, 1, 2004, "R11");
    send(1, 91, 1, 1, 2005, "R11");
    idle("R2");

    finish_run();
  end
endmodule